// File: doc/BRIEF.md
# Codec Control Command Decoder

This block sits behind the byte-serial control channel of a multi-channel voice codec. Each transaction starts with a command byte. Bit 7 of that byte gives the direction, and bits 6..0 pick a global register or an action. A write-direction command is always followed by exactly one data byte. A read-direction command takes no data byte, and the block answers it with one response byte.

The block holds two global registers. The chopper clock register carries a 2-bit and a 4-bit clock select. The companding register holds a single law-select bit. The block also answers a fixed version read, and it accepts three write-only actions:

- a no-op,
- a software reset, which pulses a reset to the per-channel local registers,
- a hardware reset, which pulses a full-reset request and returns the global registers to their defaults.

All three actions take effect only when the data byte that follows them is FFH. With any other data byte the action is dropped silently.

Command and data bytes arrive on two valid/ready inputs. A byte is taken on a clock edge where its valid and ready are both high. The sender must hold the byte stable while valid is high and ready is low. The two inputs are never ready together. The read response is a single-cycle valid pulse with no back-pressure, so the consumer must take it in the cycle it appears.

Top module: `codec_ctl_top`

## Requirements
- R1: `cmd_ready_o` is high whenever no write command is pending. After a write-direction command is taken, `cmd_ready_o` is low and `dat_ready_o` is high until a data byte is taken; after that, `cmd_ready_o` is high again. Bytes offered on an input whose ready is low are not taken.
- R2: Command bit 7 is the direction (0 = read, 1 = write) and bits 6..0 are the index. A read command never waits for a data byte. A write command always consumes the next data byte.
- R3: Reading index 20H (command 20H) returns the version value 01H.
- R4: A recognised read (20H, 24H, 26H) raises `rd_valid_o` for exactly the one cycle after the command is taken. Any other read command, including 22H and 23H, produces no response.
- R5: Command A2H followed by FFH raises `local_rst_o` for one cycle, in the cycle after the data byte is taken. The chopper and companding registers keep their values.
- R6: Command A3H followed by FFH raises `full_rst_o` for one cycle, in the cycle after the data byte is taken. In that same cycle the chopper register reads 00H and the law bit reads 0.
- R7: Command A0H followed by FFH has no visible effect. If A0H, A2H or A3H is followed by any byte other than FFH, the command is discarded and no reset pulse is issued.
- R8: Command A4H stores data bits 5..4 as the clock-2 select and bits 3..0 as the clock-1 select, and ignores bits 7..6. Command 24H returns the stored value in bits 5..0 with bits 7..6 reading 0.
- R9: Command A6H stores data bit 7 as the law select (0 = A-law, 1 = mu-law) and ignores bits 6..0. Command 26H returns the law bit in bit 7 with bits 6..0 reading 0.
- R10: A write command with any other index has its data byte taken with no effect on any output.
- R11: While `rst_n` is low at a clock edge, the block returns to its defaults: `cmd_ready_o` is 1, `dat_ready_o` is 0, all pulses are 0, the chopper selects are 0 and the law bit is 0 (A-law).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte offered |
| cmd_ready_o | output | 1 | Command byte can be taken |
| cmd_byte_i | input | 8 | Command byte: bit 7 is the direction, bits 6..0 the index |
| dat_valid_i | input | 1 | Data byte offered |
| dat_ready_o | output | 1 | Data byte can be taken |
| dat_byte_i | input | 8 | Data byte for the pending write |
| rd_valid_o | output | 1 | One-cycle read response strobe |
| rd_data_o | output | 8 | Read response byte |
| local_rst_o | output | 1 | One-cycle reset pulse to the local registers |
| full_rst_o | output | 1 | One-cycle full-reset request |
| chop2_sel_o | output | 2 | Clock-2 select |
| chop1_sel_o | output | 4 | Clock-1 select |
| law_mu_o | output | 1 | Law select: 1 = mu-law |

## Verification
A corrupted sequencer state shows up within one cycle, because `cmd_ready_o` and `dat_ready_o` expose it directly. A wrong pending-command value shows up one cycle after the following data byte: a reset pulse appears or goes missing, or a select output moves when it should not. A wrong register value shows on the select outputs at once. It shows on `rd_data_o` one cycle after the next read of that register. Because every output is compared against the reference model on every clock, each of these faults is reported within a cycle or two of the stimulus that exposes it.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIR_BIT = BYTE_W - 1;
  localparam int IDX_W   = BYTE_W - 1;

  localparam logic [IDX_W-1:0] IDX_VER  = 7'h20;
  localparam logic [IDX_W-1:0] IDX_SRST = 7'h22;
  localparam logic [IDX_W-1:0] IDX_HRST = 7'h23;
  localparam logic [IDX_W-1:0] IDX_CHOP = 7'h24;
  localparam logic [IDX_W-1:0] IDX_LAW  = 7'h26;

  typedef enum logic [2:0] {
    K_NONE,
    K_VER,
    K_NOP,
    K_SRST,
    K_HRST,
    K_CHOP,
    K_LAW
  } kind_e;

  typedef struct packed {
    logic  wr;
    kind_e kind;
  } cmd_t;

  typedef enum logic {
    S_IDLE,
    S_DATA
  } seq_state_e;
endpackage

// File: rtl/codec_cmd_decode.sv
module codec_cmd_decode
  import codec_ctl_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              dec_o
);
  logic             wr;
  logic [IDX_W-1:0] idx;

  assign wr  = byte_i[DIR_BIT];
  assign idx = byte_i[IDX_W-1:0];

  always_comb begin
    dec_o.wr   = wr;
    dec_o.kind = K_NONE;
    case (idx)
      IDX_VER:  dec_o.kind = wr ? K_NOP : K_VER;
      IDX_SRST: dec_o.kind = wr ? K_SRST : K_NONE;
      IDX_HRST: dec_o.kind = wr ? K_HRST : K_NONE;
      IDX_CHOP: dec_o.kind = K_CHOP;
      IDX_LAW:  dec_o.kind = K_LAW;
      default:  dec_o.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/codec_ctl_seq.sv
module codec_ctl_seq
  import codec_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FILL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  cmd_t              dec_i,
  output logic              cmd_ready_o,
  input  logic              dat_valid_i,
  input  logic [BYTE_W-1:0] dat_byte_i,
  output logic              dat_ready_o,
  output logic              rd_stb_o,
  output kind_e             rd_kind_o,
  output logic              wr_stb_o,
  output kind_e             wr_kind_o,
  output logic              hrst_fire_o,
  output logic              local_rst_o,
  output logic              full_rst_o
);
  seq_state_e state_q;
  kind_e      pend_q;
  logic       local_rst_q, full_rst_q;
  logic       cmd_fire, dat_fire, fill_ok, srst_fire, hrst_fire;

  assign cmd_ready_o = (state_q == S_IDLE);
  assign dat_ready_o = (state_q == S_DATA);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign dat_fire    = dat_valid_i && dat_ready_o;
  assign fill_ok     = (dat_byte_i == FILL);

  assign rd_stb_o    = cmd_fire && !dec_i.wr && (dec_i.kind != K_NONE);
  assign rd_kind_o   = dec_i.kind;
  assign wr_stb_o    = dat_fire && ((pend_q == K_CHOP) || (pend_q == K_LAW));
  assign wr_kind_o   = pend_q;
  assign srst_fire   = dat_fire && (pend_q == K_SRST) && fill_ok;
  assign hrst_fire   = dat_fire && (pend_q == K_HRST) && fill_ok;
  assign hrst_fire_o = hrst_fire;
  assign local_rst_o = local_rst_q;
  assign full_rst_o  = full_rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pend_q      <= K_NONE;
      local_rst_q <= 1'b0;
      full_rst_q  <= 1'b0;
    end else begin
      local_rst_q <= srst_fire;
      full_rst_q  <= hrst_fire;
      case (state_q)
        S_IDLE: if (cmd_fire && dec_i.wr) begin
          state_q <= S_DATA;
          pend_q  <= dec_i.kind;
        end
        S_DATA: if (dat_fire) begin
          state_q <= S_IDLE;
          pend_q  <= K_NONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1
  wr_waits_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && dec_i.wr) |=> (dat_ready_o && !cmd_ready_o));
  // R1
  data_frees_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid_i && dat_ready_o) |=> cmd_ready_o);
  // R5
  local_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_rst_o |=> !local_rst_o);
  // R6
  full_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_o |=> !full_rst_o);
  // R7
  pulse_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (local_rst_o || full_rst_o) |-> $past(dat_byte_i == FILL));
endmodule

// File: rtl/codec_glob_regs.sv
module codec_glob_regs
  import codec_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VERSION = 8'h01,
  parameter int CLK2_W  = 2,
  parameter int CLK1_W  = 4,
  parameter int LAW_BIT = 7,
  localparam int CHOP_W = CLK2_W + CLK1_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_stb_i,
  input  kind_e             wr_kind_i,
  input  logic [CHOP_W-1:0] chop_wdata_i,
  input  logic              law_wdata_i,
  input  logic              rd_stb_i,
  input  kind_e             rd_kind_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [CLK2_W-1:0] chop2_sel_o,
  output logic [CLK1_W-1:0] chop1_sel_o,
  output logic              law_mu_o
);
  logic [CHOP_W-1:0] chop_q;
  logic              law_q;
  logic [BYTE_W-1:0] chop_byte, law_byte, rd_mux;
  logic              rd_valid_q;
  logic [BYTE_W-1:0] rd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      chop_q <= '0;
      law_q  <= 1'b0;
    end else if (wr_stb_i) begin
      if (wr_kind_i == K_CHOP) chop_q <= chop_wdata_i;
      if (wr_kind_i == K_LAW)  law_q  <= law_wdata_i;
    end
  end

  // read images: every bit outside the stored field reads zero
  genvar gb;
  generate
    for (gb = 0; gb < BYTE_W; gb++) begin : g_img
      if (gb < CHOP_W) begin : g_chop
        assign chop_byte[gb] = chop_q[gb];
      end else begin : g_chop_rsvd
        assign chop_byte[gb] = 1'b0;
      end
      if (gb == LAW_BIT) begin : g_law
        assign law_byte[gb] = law_q;
      end else begin : g_law_rsvd
        assign law_byte[gb] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    case (rd_kind_i)
      K_VER:   rd_mux = VERSION;
      K_CHOP:  rd_mux = chop_byte;
      K_LAW:   rd_mux = law_byte;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_stb_i;
      if (rd_stb_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign chop2_sel_o = chop_q[CHOP_W-1 -: CLK2_W];
  assign chop1_sel_o = chop_q[CLK1_W-1:0];
  assign law_mu_o    = law_q;

  // R8
  chop_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(rd_kind_i == K_CHOP)) |-> (rd_data_o[BYTE_W-1:CHOP_W] == '0));
  // R9
  law_read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(rd_kind_i == K_LAW)) |-> (rd_data_o[LAW_BIT] == $past(law_q)));
  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_stb_i && !clr_i)) |-> ($stable(chop_q) && $stable(law_q)));
endmodule

// File: rtl/codec_ctl_top.sv
module codec_ctl_top
  import codec_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VERSION = 8'h01,
  parameter logic [BYTE_W-1:0] FILL    = 8'hFF,
  parameter int CLK2_W  = 2,
  parameter int CLK1_W  = 4,
  parameter int LAW_BIT = 7,
  localparam int CHOP_W = CLK2_W + CLK1_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  input  logic              dat_valid_i,
  output logic              dat_ready_o,
  input  logic [BYTE_W-1:0] dat_byte_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              local_rst_o,
  output logic              full_rst_o,
  output logic [CLK2_W-1:0] chop2_sel_o,
  output logic [CLK1_W-1:0] chop1_sel_o,
  output logic              law_mu_o
);
  cmd_t  dec;
  logic  rd_stb, wr_stb, hrst_fire;
  kind_e rd_kind, wr_kind;

  codec_cmd_decode u_dec (
    .byte_i (cmd_byte_i),
    .dec_o  (dec)
  );

  codec_ctl_seq #(.FILL(FILL)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .dec_i       (dec),
    .cmd_ready_o (cmd_ready_o),
    .dat_valid_i (dat_valid_i),
    .dat_byte_i  (dat_byte_i),
    .dat_ready_o (dat_ready_o),
    .rd_stb_o    (rd_stb),
    .rd_kind_o   (rd_kind),
    .wr_stb_o    (wr_stb),
    .wr_kind_o   (wr_kind),
    .hrst_fire_o (hrst_fire),
    .local_rst_o (local_rst_o),
    .full_rst_o  (full_rst_o)
  );

  codec_glob_regs #(
    .VERSION (VERSION),
    .CLK2_W  (CLK2_W),
    .CLK1_W  (CLK1_W),
    .LAW_BIT (LAW_BIT)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (hrst_fire),
    .wr_stb_i     (wr_stb),
    .wr_kind_i    (wr_kind),
    .chop_wdata_i (dat_byte_i[CHOP_W-1:0]),
    .law_wdata_i  (dat_byte_i[LAW_BIT]),
    .rd_stb_i     (rd_stb),
    .rd_kind_i    (rd_kind),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .chop2_sel_o  (chop2_sel_o),
    .chop1_sel_o  (chop1_sel_o),
    .law_mu_o     (law_mu_o)
  );

  // R6
  full_rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_o |-> (chop2_sel_o == '0 && chop1_sel_o == '0 && !law_mu_o));
  // R4
  resp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(cmd_valid_i && cmd_ready_o && !cmd_byte_i[DIR_BIT]));
  // R3
  version_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(cmd_byte_i == 8'h20)) |-> (rd_data_o == VERSION));
  // R5
  soft_rst_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_rst_o |-> ($stable(chop1_sel_o) && $stable(chop2_sel_o) && $stable(law_mu_o)));
endmodule

// File: tb/codec_ctl_top_tb_top.sv
`timescale 1ns/1ps
module codec_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       dat_valid = 1'b0;
  logic [7:0] dat_byte = 8'h00;
  logic       cmd_ready, dat_ready, rd_valid, local_rst, full_rst, law_mu;
  logic [7:0] rd_data;
  logic [1:0] chop2;
  logic [3:0] chop1;

  always #2.5 clk = ~clk;

  codec_ctl_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_byte_i  (cmd_byte),
    .dat_valid_i (dat_valid),
    .dat_ready_o (dat_ready),
    .dat_byte_i  (dat_byte),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .local_rst_o (local_rst),
    .full_rst_o  (full_rst),
    .chop2_sel_o (chop2),
    .chop1_sel_o (chop1),
    .law_mu_o    (law_mu)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_lrst = 0, n_frst = 0, n_rv = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  bit      m_pend;
  int      m_cmd;
  int      m_chop, m_law;
  bit      e_rv, e_lrst, e_frst;
  int      e_rdata;
  string   e_rtag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    e_rv = 0; e_lrst = 0; e_frst = 0;
    if (!rst_n) begin
      m_pend = 0; m_cmd = 0; m_chop = 0; m_law = 0;
    end else if (!m_pend) begin
      if (cmd_valid) begin
        if (cmd_byte[7]) begin
          m_pend = 1; m_cmd = int'(cmd_byte);
        end else if (cmd_byte == 8'h20) begin
          e_rv = 1; e_rdata = 8'h01; e_rtag = "R3";
        end else if (cmd_byte == 8'h24) begin
          e_rv = 1; e_rdata = m_chop; e_rtag = "R8";
        end else if (cmd_byte == 8'h26) begin
          e_rv = 1; e_rdata = m_law * 128; e_rtag = "R9";
        end
      end
    end else if (dat_valid) begin
      m_pend = 0;
      if (m_cmd == 'hA2 && dat_byte == 8'hFF) e_lrst = 1;
      if (m_cmd == 'hA3 && dat_byte == 8'hFF) begin
        e_frst = 1; m_chop = 0; m_law = 0;
      end
      if (m_cmd == 'hA4) m_chop = int'(dat_byte) % 64;
      if (m_cmd == 'hA6) m_law = int'(dat_byte) / 128;
    end
    if (!rst_n) cmp_en = 1;
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cmd_ready == !m_pend, "R1", "cmd_ready", cmd_ready, !m_pend);
      chk(dat_ready == m_pend, "R1", "dat_ready", dat_ready, m_pend);
      chk(rd_valid == e_rv, "R4", "rd_valid", rd_valid, e_rv);
      if (e_rv) chk(rd_data == e_rdata[7:0], e_rtag, "rd_data", rd_data, e_rdata);
      chk(local_rst == e_lrst, "R5", "local_rst", local_rst, e_lrst);
      chk(full_rst == e_frst, "R6", "full_rst", full_rst, e_frst);
      chk({chop2, chop1} == m_chop[5:0], "R8", "chop_sel", {chop2, chop1}, m_chop);
      chk(law_mu == m_law[0], "R9", "law_mu", law_mu, m_law);
      if (local_rst) n_lrst++;
      if (full_rst) n_frst++;
      if (rd_valid) n_rv++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_cmd(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic send_dat(input logic [7:0] b);
    dat_valid = 1'b1; dat_byte = b;
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0; dat_byte = 8'h00;
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    send_cmd(c);
    send_dat(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int l0, f0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(cmd_ready == 1 && dat_ready == 0, "R11", "ready after reset", {cmd_ready, dat_ready}, 2'b10);
    chk({chop2, chop1, law_mu} == 7'd0, "R11", "regs after reset", {chop2, chop1, law_mu}, 0);
    // R3 version read and defaults
    send_cmd(8'h20);
    chk(rd_valid && rd_data == 8'h01, "R3", "version", rd_data, 8'h01);
    send_cmd(8'h24); send_cmd(8'h26); idle(1);
    // R2 write direction waits for data
    send_cmd(8'hA4);
    chk(dat_ready == 1, "R2", "write waits data", dat_ready, 1);
    send_dat(8'hE9);
    chk({chop2, chop1} == 6'h29, "R8", "chop store", {chop2, chop1}, 6'h29);
    send_cmd(8'h24);
    chk(rd_valid && rd_data == 8'h29, "R8", "chop read rsvd zero", rd_data, 8'h29);
    chk(dat_ready == 0, "R2", "read needs no data", dat_ready, 0);
    // R9 law select
    wr(8'hA6, 8'h80); send_cmd(8'h26);
    chk(rd_data == 8'h80, "R9", "law read", rd_data, 8'h80);
    wr(8'hA6, 8'h7F);
    chk(law_mu == 0, "R9", "law low bits ignored", law_mu, 0);
    wr(8'hA6, 8'hFF); wr(8'hA4, 8'h16); idle(2);
    // R5 software reset
    l0 = n_lrst;
    wr(8'hA2, 8'hFF); idle(3);
    chk(n_lrst == l0 + 1, "R5", "local pulse count", n_lrst, l0 + 1);
    chk(law_mu == 1 && {chop2, chop1} == 6'h16, "R5", "globals kept", {law_mu, chop2, chop1}, 7'h56);
    // R7 discarded actions
    l0 = n_lrst; f0 = n_frst;
    wr(8'hA2, 8'hFE); wr(8'hA3, 8'h00); wr(8'hA0, 8'h7F); wr(8'hA0, 8'hFF); idle(3);
    chk(n_lrst == l0 && n_frst == f0, "R7", "no pulses", n_lrst + n_frst, l0 + f0);
    chk(law_mu == 1 && {chop2, chop1} == 6'h16, "R7", "globals kept", {law_mu, chop2, chop1}, 7'h56);
    // R10 unknown write indices
    wr(8'hA9, 8'hFF); wr(8'hB5, 8'h00); wr(8'hFF, 8'h3F); idle(3);
    chk(law_mu == 1 && {chop2, chop1} == 6'h16, "R10", "unknown write inert", {law_mu, chop2, chop1}, 7'h56);
    chk(n_lrst == l0 && n_frst == f0, "R10", "unknown write no pulse", n_lrst + n_frst, l0 + f0);
    // R4 unrecognised reads produce nothing
    r0 = n_rv;
    send_cmd(8'h22); send_cmd(8'h23); send_cmd(8'h7F); send_cmd(8'h00); idle(3);
    chk(n_rv == r0, "R4", "no response", n_rv, r0);
    // R4 back-to-back reads
    send_cmd(8'h20); send_cmd(8'h24); send_cmd(8'h26); idle(2);
    chk(n_rv == r0 + 3, "R4", "three responses", n_rv, r0 + 3);
    // R1 back-pressure: read offered while a write waits for data
    fork
      begin send_cmd(8'hA4); repeat (3) @(negedge clk); send_dat(8'h0C); end
      begin
        repeat (2) @(negedge clk);
        chk(cmd_ready == 0, "R1", "cmd held off", cmd_ready, 0);
        send_cmd(8'h24);
        chk(rd_data == 8'h0C, "R1", "read after data", rd_data, 8'h0C);
      end
    join
    // R1 data offered while idle is not taken
    dat_valid = 1'b1; dat_byte = 8'h3F; idle(2); dat_valid = 1'b0;
    chk({chop2, chop1} == 6'h0C, "R1", "idle data ignored", {chop2, chop1}, 6'h0C);
    // R6 hardware reset
    f0 = n_frst;
    send_cmd(8'hA3); dat_valid = 1'b1; dat_byte = 8'hFF; @(negedge clk);
    dat_valid = 1'b0;
    chk(full_rst == 1 && {chop2, chop1, law_mu} == 7'd0, "R6", "full reset defaults",
        {full_rst, chop2, chop1, law_mu}, 8'h80);
    idle(2);
    chk(n_frst == f0 + 1, "R6", "one full pulse", n_frst, f0 + 1);
    // R11 external reset mid-transaction
    wr(8'hA4, 8'h3F); wr(8'hA6, 8'h80); send_cmd(8'hA6);
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    chk(cmd_ready == 1 && dat_ready == 0, "R11", "ready after mid reset", {cmd_ready, dat_ready}, 2'b10);
    chk({chop2, chop1, law_mu} == 7'd0, "R11", "regs after mid reset", {chop2, chop1, law_mu}, 0);
    send_cmd(8'h26); idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule